// File: doc/BRIEF.md
# Power-On Camera Register Loader

This block configures an image sensor straight out of reset, with no host involved. It steps through a fixed table of register sub-address/value pairs. For each pair it issues one write transaction on the sensor's two-wire serial control bus, which is a simplified I2C variant. When it reaches an entry that carries the reserved end marker, it stops and raises a completion flag. Read cycles and acknowledge checking are not part of the block. The master drives the data line only for the bits it sends, and releases it during every ninth (acknowledge) bit period.

Control is split over three state-machine layers:

- **Sequencer.** The top-level sequencer fetches table entries and starts one transaction per entry.
- **Cycle layer.** The transaction layer breaks each write into a start condition, three bytes, a stop condition and an idle gap. The three bytes are the device ID, the sub-address and the data, in that order.
- **Bit layer.** The bus layer turns each symbol into clock and data levels. It divides every bit period into four equal quarters.

Both bus pins are open-drain. An enable output of 1 pulls the line low, and 0 releases it to the pull-up.

Top module: `cam_reg_init`

## Requirements
- R1: During and directly after reset, `scl_oe`, `sda_oe` and `done` are all 0, so both lines are released.
- R2: Every table entry before the end marker produces exactly one write transaction, in table order. A transaction is a start condition, then three bytes (DEV_ID, sub-address, value), then a stop condition.
- R3: Each byte is sent most significant bit first. It is followed by a ninth bit period in which the data line is released, so it reads as 1.
- R4: While the clock line is high, the data line changes only for a start condition (data falls) or a stop condition (data rises). No start appears inside a transaction, and a stop appears only after all 27 bit periods.
- R5: Each clock-high pulse inside a transaction lasts exactly 2*Q system clock cycles, where Q = CLK_HZ/(4*BUS_HZ).
- R6: Between the stop of one transaction and the start of the next, both lines stay released for at least GAP_BITS*4*Q system cycles.
- R7: The sequence ends at the first table entry whose sub-address is 8'hFF. `done` stays 0 until after the final stop condition, then rises and stays 1. From then on both lines stay released.
- R8: Table entry i, for i < N_REGS, holds sub-address 8'h10 + 3*i and value 8'hA5 XOR (i*8'h1D mod 256). Entry N_REGS holds the end marker 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_oe | output | 1 | 1 pulls the bus clock line low |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| done | output | 1 | All table writes finished; stays high |

## Verification
The in-RTL properties check the following on every cycle:

- The data line holds steady through each clock-high window of a data bit.
- The quarter counter stays in range.
- Bus symbols and transactions are only requested when the layer below is idle.
- `done` never falls, and the bus stays released once `done` is high.

Only the bench scenario can show the rest. It decodes the bus from the pins and checks the byte contents and their order against the computed table. It also checks the released ninth bits, the exact clock-high widths, the gap lengths and the number of transactions before completion.

// File: rtl/cam_init_pkg.sv
// Shared types for the power-on camera register loader.
package cam_init_pkg;
    // Bus symbols that the cycle layer asks the bit layer to produce.
    typedef enum logic [1:0] {BC_START, BC_BIT, BC_STOP, BC_GAP} bus_cmd_e;
    // A table sub-address equal to this value ends the sequence.
    localparam logic [7:0] END_MARK = 8'hFF;
    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] val;
    } reg_pair_t;
endpackage

// File: rtl/cam_cfg_rom.sv
// Computed configuration table. Entry i < N_REGS holds sub-address
// 8'h10+3*i and value 8'hA5^(i*8'h1D). Every later index returns the end
// marker. Assumes N_REGS < 80, so no real entry collides with the marker.
module cam_cfg_rom
    import cam_init_pkg::*;
#(
    parameter int N_REGS = 4,
    parameter int PTR_W  = $clog2(N_REGS + 1)
) (
    input  logic [PTR_W-1:0] ptr,
    output reg_pair_t        entry
);
    logic [7:0] p8;
    assign p8 = 8'(ptr);

    // Derive the entry arithmetically from its index.
    always_comb begin
        if (ptr < PTR_W'(N_REGS)) begin
            entry.sub = 8'h10 + p8 * 8'd3;
            entry.val = 8'hA5 ^ (p8 * 8'h1D);
        end else begin
            entry.sub = END_MARK;
            entry.val = 8'h00;
        end
    end
endmodule

// File: rtl/cam_bus_phy.sv
// Bit layer. It plays one bus symbol at a time as four quarters of
// QTR_CYCLES system cycles each, and drives open-drain enables (1 = pull low).
// A symbol is accepted only while ready is high. Between symbols the
// outputs hold their last levels.
module cam_bus_phy
    import cam_init_pkg::*;
#(
    parameter int QTR_CYCLES = 250
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  bus_cmd_e cmd,
    input  logic     cmd_bit,
    output logic     ready,
    output logic     cmd_done,
    output logic     scl_oe,
    output logic     sda_oe
);
    localparam int CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYCLES - 1);

    logic             active;
    bus_cmd_e         cmd_r;
    logic             bit_r;
    logic [1:0]       qtr;
    logic [CNT_W-1:0] cnt;
    logic             scl_hi, sda_hi;

    assign ready    = !active;
    assign cmd_done = active && (qtr == 2'd3) && (cnt == CNT_LAST);

    // Line levels for the current symbol and quarter.
    always_comb begin
        unique case (cmd_r)
            BC_START: begin scl_hi = (qtr != 2'd3); sda_hi = (qtr < 2'd2);  end
            BC_BIT:   begin scl_hi = (qtr == 2'd1) || (qtr == 2'd2); sda_hi = bit_r; end
            BC_STOP:  begin scl_hi = (qtr != 2'd0); sda_hi = (qtr >= 2'd2); end
            default:  begin scl_hi = 1'b1; sda_hi = 1'b1; end
        endcase
    end

    // Symbol acceptance, quarter timing and registered pin enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cmd_r  <= BC_GAP;
            bit_r  <= 1'b1;
            qtr    <= 2'd0;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else if (!active) begin
            if (cmd_valid) begin
                active <= 1'b1;
                cmd_r  <= cmd;
                bit_r  <= cmd_bit;
                qtr    <= 2'd0;
                cnt    <= '0;
            end
        end else begin
            scl_oe <= !scl_hi;
            sda_oe <= !sda_hi;
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                qtr <= qtr + 2'd1;
                if (qtr == 2'd3) active <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R4: the data enable holds while the clock stays high inside a data bit.
    a_r4_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && cmd_r == BC_BIT) |-> $stable(sda_oe));
    // R5: the quarter counter never passes its limit.
    a_r5_qtr_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= CNT_LAST));
    // R2: a new symbol is only offered while the bit layer is idle.
    a_r2_cmd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !active);
endmodule

// File: rtl/cam_write_cycle.sv
// Cycle layer. It expands one write into a start, 27 bit periods
// (three bytes MSB first, each with a released ninth bit), a stop, and
// GAP_BITS idle bit periods. It pulses wr_done when the write completes.
// Assumes GAP_BITS >= 1 and that start arrives only while the layer is idle.
module cam_write_cycle
    import cam_init_pkg::*;
#(
    parameter int GAP_BITS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] dev_id,
    input  logic [7:0] sub,
    input  logic [7:0] val,
    output logic       wr_done,
    output logic       cmd_valid,
    output bus_cmd_e   cmd,
    output logic       cmd_bit,
    input  logic       sym_done
);
    localparam int GAP_W = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

    typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} wstate_e;

    wstate_e          state;
    bus_cmd_e         ph;
    logic [23:0]      tx_sr;
    logic [1:0]       byte_idx;
    logic [3:0]       bit_idx;
    logic [GAP_W-1:0] gap_cnt;

    assign cmd_valid = (state == W_ISSUE);
    assign cmd       = ph;
    assign cmd_bit   = (bit_idx == 4'd8) ? 1'b1 : tx_sr[23];

    // Step through the symbols of one write, one symbol per bit-layer completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            ph       <= BC_START;
            tx_sr    <= '0;
            byte_idx <= 2'd0;
            bit_idx  <= 4'd0;
            gap_cnt  <= '0;
            wr_done  <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            unique case (state)
                W_IDLE: if (start) begin
                    tx_sr    <= {dev_id, sub, val};
                    ph       <= BC_START;
                    byte_idx <= 2'd0;
                    bit_idx  <= 4'd0;
                    gap_cnt  <= '0;
                    state    <= W_ISSUE;
                end
                W_ISSUE: state <= W_WAIT;
                W_WAIT: if (sym_done) begin
                    state <= W_ISSUE;
                    unique case (ph)
                        BC_START: ph <= BC_BIT;
                        BC_BIT: begin
                            if (bit_idx == 4'd8) begin
                                bit_idx <= 4'd0;
                                if (byte_idx == 2'd2) ph <= BC_STOP;
                                else byte_idx <= byte_idx + 2'd1;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                                tx_sr   <= {tx_sr[22:0], 1'b0};
                            end
                        end
                        BC_STOP: ph <= BC_GAP;
                        default: begin
                            if (gap_cnt == GAP_W'(GAP_BITS - 1)) begin
                                state   <= W_IDLE;
                                wr_done <= 1'b1;
                            end else begin
                                gap_cnt <= gap_cnt + GAP_W'(1);
                            end
                        end
                    endcase
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R2: the sequencer never starts a write while one is in progress.
    a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == W_IDLE));
endmodule

// File: rtl/cam_reg_init.sv
// Power-on register loader top. The sequencer walks the computed table
// and issues one write per entry. It stops at the end marker and raises
// done. Bus clock quarter = CLK_HZ/(4*BUS_HZ) system cycles (must be >= 1).
module cam_reg_init
    import cam_init_pkg::*;
#(
    parameter int         CLK_HZ   = 100_000_000,
    parameter int         BUS_HZ   = 100_000,
    parameter int         N_REGS   = 4,
    parameter int         GAP_BITS = 3,
    parameter logic [7:0] DEV_ID   = 8'h42
) (
    input  logic clk,
    input  logic rst_n,
    output logic scl_oe,
    output logic sda_oe,
    output logic done
);
    localparam int QTR   = CLK_HZ / (4 * BUS_HZ);
    localparam int PTR_W = $clog2(N_REGS + 1);

    typedef enum logic [1:0] {S_FETCH, S_WAIT, S_DONE} sstate_e;

    sstate_e          state;
    logic [PTR_W-1:0] ptr;
    reg_pair_t        entry;
    logic             wr_start, wr_done;
    logic             cmd_valid, cmd_bit, phy_ready, sym_done;
    bus_cmd_e         cmd;

    cam_cfg_rom #(.N_REGS(N_REGS), .PTR_W(PTR_W)) u_rom (
        .ptr(ptr), .entry(entry));

    cam_write_cycle #(.GAP_BITS(GAP_BITS)) u_cyc (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .dev_id(DEV_ID),
        .sub(entry.sub), .val(entry.val), .wr_done(wr_done),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bit(cmd_bit), .sym_done(sym_done));

    cam_bus_phy #(.QTR_CYCLES(QTR)) u_phy (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .cmd_bit(cmd_bit), .ready(phy_ready), .cmd_done(sym_done),
        .scl_oe(scl_oe), .sda_oe(sda_oe));

    assign wr_start = (state == S_FETCH) && (entry.sub != END_MARK);

    // Table walk: fetch an entry, run its write, stop at the marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            ptr   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (state)
                S_FETCH: begin
                    if (entry.sub == END_MARK) begin
                        state <= S_DONE;
                        done  <= 1'b1;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: if (wr_done) begin
                    ptr   <= ptr + PTR_W'(1);
                    state <= S_FETCH;
                end
                default: state <= S_DONE;
            endcase
        end
    end

    // R7: done never falls once raised.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> done);
    // R7: after done, both lines stay released and the bit layer stays idle.
    a_r7_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_oe && !sda_oe && phy_ready));
    // R8: the pointer never walks past the end-marker entry.
    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(N_REGS));
endmodule

// File: tb/cam_reg_init_test.sv
// Bench: decodes the bus from the pins and checks every transaction
// against the table computed from R8.
module cam_reg_init_test;
    localparam int         CLK_HZ = 100_000_000;
    localparam int         BUS_HZ = 6_250_000;
    localparam int         NR     = 4;
    localparam int         GAPB   = 3;
    localparam logic [7:0] DEV    = 8'h42;
    localparam int         Q      = CLK_HZ / (4 * BUS_HZ);

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_oe, sda_oe, done;
    int   total = 0, bad = 0;

    always #5 clk = ~clk;

    cam_reg_init #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .N_REGS(NR),
                   .GAP_BITS(GAPB), .DEV_ID(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sub(input int i);
        return 8'h10 + 8'(i) * 8'd3;
    endfunction
    function automatic logic [7:0] exp_val(input int i);
        return 8'hA5 ^ (8'(i) * 8'h1D);
    endfunction

    // Bus decoder state.
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    bit   in_txn = 0, rose_in = 0, seen_stop = 0;
    int   nbits = 0, hi_len = 0, txn = 0, idle_len = 0;
    logic bits [32];

    // Decode start/stop/bits at negedge, away from the active edge.
    always @(negedge clk) begin
        logic scl, sda;
        if (rst_n) begin
            scl = !scl_oe;
            sda = !sda_oe;
            if (!in_txn) idle_len++;
            if (scl && prev_scl && prev_sda && !sda) begin
                // R4: no start inside a transaction.
                chk(!in_txn, "R4 start inside txn", nbits, 0);
                if (seen_stop) chk(idle_len >= GAPB * 4 * Q, "R6 gap", idle_len, GAPB * 4 * Q);
                in_txn = 1; nbits = 0; rose_in = 0;
            end else if (scl && prev_scl && !prev_sda && sda) begin
                // The stop's own clock rise is sampled as a 28th bit.
                chk(nbits == 28, "R4 stop position", nbits, 28);
                chk(!done, "R7 done low at stop", done, 0);
                if (nbits == 28 && txn < NR) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [7:0] b;
                        logic [7:0] e;
                        b = '0;
                        for (int j = 0; j < 8; j++) b = {b[6:0], bits[9*k+j]};
                        e = (k == 0) ? DEV : (k == 1) ? exp_sub(txn) : exp_val(txn);
                        chk(b == e, (k == 0) ? "R2 device id" : "R8 table byte", b, e);
                        chk(bits[9*k+8] == 1'b1, "R3 ninth bit released", bits[9*k+8], 1);
                    end
                end
                txn++; in_txn = 0; seen_stop = 1; idle_len = 0;
            end
            if (scl && !prev_scl) begin
                if (in_txn && nbits < 32) begin bits[nbits] = sda; nbits++; end
                hi_len = 1; rose_in = in_txn;
            end else if (scl) begin
                hi_len++;
            end else if (prev_scl && rose_in) begin
                chk(hi_len == 2 * Q, "R5 clock high width", hi_len, 2 * Q);
                rose_in = 0;
            end
            prev_scl = scl;
            prev_sda = sda;
        end
    end

    initial begin
        int cyc;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(scl_oe == 0, "R1 scl released in reset", scl_oe, 0);
        chk(sda_oe == 0, "R1 sda released in reset", sda_oe, 0);
        chk(done == 0, "R1 done low in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !done, "R1 state after reset", {scl_oe, sda_oe, done}, 0);
        cyc = 0;
        while (!done && cyc < 50000) begin @(negedge clk); cyc++; end
        chk(done == 1'b1, "R7 done reached (watchdog)", done, 1);
        chk(txn == NR, "R7 transaction count at done", txn, NR);
        chk(!in_txn, "R7 done after final stop", in_txn, 0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe || !done) begin
                chk(0, "R7 quiet after done", {scl_oe, sda_oe, done}, 1);
                break;
            end
        end
        chk(txn == NR, "R7 no extra transactions", txn, NR);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule